// File: doc/BRIEF.md
# DDS Serial Load Controller

The block drives the three-wire serial control port of a direct digital synthesis clock generator from a simple parallel request interface. After power-up, or after a synchronous restart, it first drives a master reset pulse of programmable width. It then waits a programmable quiet period and issues the serial-mode entry sequence. That sequence is one word-clock pulse followed by one update-strobe pulse. The board ties the device's parallel data pins D0 and D1 high and D2 low, so this pulse pair selects serial mode. The init-done output rises once the entry sequence is complete.

From then on, each accepted request supplies a 32-bit frequency tuning word, a power-down flag and a 5-bit phase code. The caller computes these codes. The tuning word is the output frequency times 2^32 divided by the reference clock, and the phase code is a 5-bit fraction of a full turn. The block captures the three fields into a 40-bit load word. It shifts the word out least-significant bit first on a data/clock pair, with the clock idling low and data stable before each rising edge. It then commits the word with a single update-strobe pulse.

All timing is counted in system clock cycles. The parameters set the half word-clock period, the reset width, the post-reset wait and the strobe width. At 100 MHz the defaults exceed 5 and 13 reference periods for any reference clock of 1 MHz or faster.

Top module: `dds_load_ctrl`

## Requirements
- R1: The load word has the tuning word in bits 0 to 31, zeros in bits 32 and 33, the power-down flag in bit 34 and the phase code in bits 35 to 39 (phase bit 0 in word bit 35).
- R2: The word is sent bit 0 first, one bit per word-clock rising edge, and exactly 40 rising edges occur between the strobe that ends one load and the strobe of the next load.
- R3: The word clock idles low, and the data line holds the same value for HALF_CYC cycles before every rising edge and stays stable across it.
- R4: The update strobe idles low and pulses high for exactly STB_CYC cycles after the 40th bit of each load, and once during the entry sequence.
- R5: While rst_ni is low, and for at least RST_CYC cycles after rst_ni is released or a restart is taken, the device reset output is high.
- R6: After the device reset output falls, neither the word clock nor the update strobe rises for at least WAIT_CYC cycles.
- R7: The entry sequence has exactly one word-clock pulse followed by one update-strobe pulse. The init-done output rises only after that strobe has returned low, and it is low during reset.
- R8: req_ready_o is high only when init is done and no load is in progress. A request is taken on a cycle where req_valid_i and req_ready_o are both high. busy_o stays high from acceptance until the update strobe is low again, and requests offered while busy are not taken.
- R9: Changes to the request fields after a request is accepted do not alter the word being sent.
- R10: A one-cycle srst_i pulse aborts any load in progress, drops init-done and ready, raises the device reset output on the next cycle and reruns the whole power-up sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srst_i | input | 1 | Synchronous restart of the power-up sequence |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can take a request |
| ftw_i | input | 32 | Frequency tuning word |
| pdn_i | input | 1 | Power-down flag |
| phase_i | input | 5 | Phase code |
| busy_o | output | 1 | Power-up sequence or load in progress |
| init_done_o | output | 1 | Serial mode entered |
| dev_rst_o | output | 1 | Device master reset |
| wclk_o | output | 1 | Word clock, idles low |
| sdata_o | output | 1 | Serial data |
| fq_ud_o | output | 1 | Update strobe, idles low |

## Verification
A wrong bit counter or shift state shows up within one load as a strobe after the wrong number of clock edges, or as a captured word that differs from the expected packing. The monitor compares each load word in full and counts the edges. A wrong timer value or state jump during power-up shows up at the first device-reset fall or the first entry pulse, as a measured width or gap below its minimum. A broken handshake shows up within one transfer as a duplicated or lost word in the scoreboard, or as ready high while busy.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int FTW_W  = 32;
  localparam int PH_W   = 5;
  localparam int WORD_W = FTW_W + 2 + 1 + PH_W;

  typedef enum logic [3:0] {
    ST_RST, ST_RWAIT, ST_EHI, ST_ELO, ST_EUPD, ST_EGAP,
    ST_IDLE, ST_LO, ST_HI, ST_UPD
  } st_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // reserved bits between power-down and tuning word are forced low
  function automatic logic [WORD_W-1:0] pack_word(logic [FTW_W-1:0] ftw,
                                                  logic pdn,
                                                  logic [PH_W-1:0] ph);
    return {ph, pdn, 2'b00, ftw};
  endfunction
endpackage

// File: rtl/dds_tmr.sv
module dds_tmr #(
  parameter int CNT_W   = 11,
  parameter int RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)      cnt_q <= val_i - CNT_W'(1);
    else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dds_shreg.sv
module dds_shreg #(
  parameter int W = 40,
  localparam int BW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         bit_o,
  output logic         last_o
);
  logic [W-1:0]  sr_q;
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= word_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {1'b0, sr_q[W-1:1]};
      cnt_q <= cnt_q + BW'(1);
    end
  end

  assign bit_o  = sr_q[0];
  assign last_o = (cnt_q == BW'(W-1));
endmodule

// File: rtl/dds_seq.sv
module dds_seq import dds_pkg::*; #(
  parameter int HALF_CYC = 4,
  parameter int RST_CYC  = 600,
  parameter int WAIT_CYC = 1400,
  parameter int STB_CYC  = 4,
  parameter int CNT_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             req_valid_i,
  input  logic             tmr_done_i,
  input  logic             last_bit_i,
  output st_e              st_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             sh_load_o,
  output logic             sh_shift_o,
  output logic             init_done_o
);
  st_e  st_q, st_d;
  logic done_q;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    sh_load_o  = 1'b0;
    sh_shift_o = 1'b0;
    if (srst_i) begin
      st_d       = ST_RST;
      tmr_load_o = 1'b1;
      tmr_val_o  = CNT_W'(RST_CYC);
    end else begin
      unique case (st_q)
        ST_RST: if (tmr_done_i) begin
          st_d = ST_RWAIT; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(WAIT_CYC);
        end
        ST_RWAIT: if (tmr_done_i) begin
          st_d = ST_EHI; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(HALF_CYC);
        end
        ST_EHI: if (tmr_done_i) begin
          st_d = ST_ELO; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(HALF_CYC);
        end
        ST_ELO: if (tmr_done_i) begin
          st_d = ST_EUPD; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(STB_CYC);
        end
        ST_EUPD: if (tmr_done_i) begin
          st_d = ST_EGAP; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(STB_CYC);
        end
        ST_EGAP: if (tmr_done_i) st_d = ST_IDLE;
        ST_IDLE: if (req_valid_i) begin
          st_d = ST_LO; sh_load_o = 1'b1;
          tmr_load_o = 1'b1; tmr_val_o = CNT_W'(HALF_CYC);
        end
        ST_LO: if (tmr_done_i) begin
          st_d = ST_HI; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(HALF_CYC);
        end
        ST_HI: if (tmr_done_i) begin
          sh_shift_o = 1'b1;
          tmr_load_o = 1'b1;
          if (last_bit_i) begin
            st_d = ST_UPD; tmr_val_o = CNT_W'(STB_CYC);
          end else begin
            st_d = ST_LO;  tmr_val_o = CNT_W'(HALF_CYC);
          end
        end
        ST_UPD: if (tmr_done_i) st_d = ST_IDLE;
        default: st_d = ST_RST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RST;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (srst_i)                            done_q <= 1'b0;
      else if (st_q == ST_EGAP && tmr_done_i) done_q <= 1'b1;
    end
  end

  assign st_o        = st_q;
  assign init_done_o = done_q;
endmodule

// File: rtl/dds_load_ctrl.sv
module dds_load_ctrl import dds_pkg::*; #(
  parameter int HALF_CYC = 4,
  parameter int RST_CYC  = 600,
  parameter int WAIT_CYC = 1400,
  parameter int STB_CYC  = 4,
  localparam int MAX_CYC = max2(max2(HALF_CYC, STB_CYC), max2(RST_CYC, WAIT_CYC)),
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [FTW_W-1:0] ftw_i,
  input  logic             pdn_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic             busy_o,
  output logic             init_done_o,
  output logic             dev_rst_o,
  output logic             wclk_o,
  output logic             sdata_o,
  output logic             fq_ud_o
);
  st_e              st;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_bit, sh_last;

  dds_seq #(
    .HALF_CYC(HALF_CYC), .RST_CYC(RST_CYC), .WAIT_CYC(WAIT_CYC),
    .STB_CYC(STB_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i, .rst_ni, .srst_i, .req_valid_i,
    .tmr_done_i(tmr_done), .last_bit_i(sh_last),
    .st_o(st), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .sh_load_o(sh_load), .sh_shift_o(sh_shift), .init_done_o
  );

  dds_tmr #(.CNT_W(CNT_W), .RST_VAL(RST_CYC - 1)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  dds_shreg #(.W(WORD_W)) u_shreg (
    .clk_i, .rst_ni, .load_i(sh_load),
    .word_i(pack_word(ftw_i, pdn_i, phase_i)),
    .shift_i(sh_shift), .bit_o(sh_bit), .last_o(sh_last)
  );

  assign dev_rst_o   = (st == ST_RST);
  assign wclk_o      = (st == ST_EHI) || (st == ST_HI);
  assign fq_ud_o     = (st == ST_EUPD) || (st == ST_UPD);
  assign sdata_o     = ((st == ST_LO) || (st == ST_HI)) && sh_bit;
  assign req_ready_o = (st == ST_IDLE);
  assign busy_o      = (st != ST_IDLE);
endmodule

// File: rtl/dds_load_ctrl_chk.sv
module dds_load_ctrl_chk import dds_pkg::*; #(
  parameter int HALF_CYC = 4,
  parameter int RST_CYC  = 600,
  parameter int WAIT_CYC = 1400,
  parameter int STB_CYC  = 4,
  localparam int CW = $clog2(max2(max2(RST_CYC, WAIT_CYC), STB_CYC) + 2)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic srst_i,
  input logic req_ready_o,
  input logic busy_o,
  input logic init_done_o,
  input logic dev_rst_o,
  input logic wclk_o,
  input logic sdata_o,
  input logic fq_ud_o
);
  logic [CW-1:0] rst_w, quiet, stb_w;
  logic [6:0]    nb;
  logic          wclk_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_w <= '0; quiet <= '0; stb_w <= '0; nb <= '0; wclk_p <= 1'b0;
    end else begin
      wclk_p <= wclk_o;
      if (dev_rst_o) rst_w <= (rst_w < CW'(RST_CYC)) ? rst_w + CW'(1) : rst_w;
      else           rst_w <= '0;
      if (dev_rst_o)                 quiet <= '0;
      else if (quiet < CW'(WAIT_CYC)) quiet <= quiet + CW'(1);
      if (fq_ud_o) stb_w <= stb_w + CW'(1);
      else         stb_w <= '0;
      if (fq_ud_o || dev_rst_o)   nb <= '0;
      else if (wclk_o && !wclk_p) nb <= nb + 7'd1;
    end
  end

  p_rst_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_rst_o) |-> rst_w >= CW'(RST_CYC));
  p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wclk_o) || $rose(fq_ud_o)) |-> quiet >= CW'(WAIT_CYC));
  p_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wclk_o) |-> $stable(sdata_o));
  p_strobe_w_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fq_ud_o) |-> stb_w == CW'(STB_CYC));
  p_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_o && $rose(fq_ud_o)) |-> nb == 7'd40);
  p_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (init_done_o && !busy_o && !fq_ud_o && !wclk_o));
  p_init_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> (!fq_ud_o && !dev_rst_o));
  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (dev_rst_o && !init_done_o && !req_ready_o));
endmodule

bind dds_load_ctrl dds_load_ctrl_chk #(
  .HALF_CYC(HALF_CYC), .RST_CYC(RST_CYC), .WAIT_CYC(WAIT_CYC), .STB_CYC(STB_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i), .req_ready_o(req_ready_o),
  .busy_o(busy_o), .init_done_o(init_done_o), .dev_rst_o(dev_rst_o),
  .wclk_o(wclk_o), .sdata_o(sdata_o), .fq_ud_o(fq_ud_o)
);

// File: tb/dds_load_ctrl_tb_top.sv
module dds_load_ctrl_tb_top;
  localparam int HALF = 4, RSTC = 600, WAITC = 1400, STB = 4;

  logic clk = 1'b0, rst_ni = 1'b0, srst = 1'b0, valid = 1'b0;
  logic [31:0] ftw = '0;
  logic pdn = 1'b0;
  logic [4:0] ph = '0;
  logic ready, busy, idone, drst, wclk, sdata, fq;

  int tests = 0, fails = 0, accepted = 0, strobes = 0;
  bit finished = 1'b0;
  logic [39:0] exp_q[$];

  always #5 clk = ~clk;

  dds_load_ctrl #(.HALF_CYC(HALF), .RST_CYC(RSTC), .WAIT_CYC(WAITC), .STB_CYC(STB)) dut_i (
    .clk_i(clk), .rst_ni, .srst_i(srst), .req_valid_i(valid), .req_ready_o(ready),
    .ftw_i(ftw), .pdn_i(pdn), .phase_i(ph), .busy_o(busy), .init_done_o(idone),
    .dev_rst_o(drst), .wclk_o(wclk), .sdata_o(sdata), .fq_ud_o(fq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: offer one request, push the expected word on acceptance, then scramble inputs (R9)
  task automatic send(input logic [31:0] f, input logic p, input logic [4:0] a);
    do @(negedge clk); while (!ready);
    ftw = f; pdn = p; ph = a; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    exp_q.push_back({a, p, 2'b00, f});
    accepted++;
    ftw = ~f; pdn = ~p; ph = ~a;
  endtask

  // monitor
  initial begin
    logic [39:0] cap = '0, exp_w;
    int bits = 0, rst_w = 0, quiet = 0, stb_w = 0, epulses = 0;
    logic p_wclk = 0, p_fq = 0, p_drst = 1, p_sdata = 0, p_idone = 0;
    forever begin
      @(negedge clk);
      if (drst) begin
        rst_w++; quiet = 0; bits = 0; epulses = 0;
      end else quiet++;
      if (p_drst && !drst) begin
        chk(rst_w >= RSTC, "R5", "reset width", 64'(rst_w), 64'(RSTC));
        rst_w = 0;
      end
      if (wclk && !p_wclk) begin
        if (!idone) begin
          epulses++;
          chk(quiet > WAITC, "R6", "quiet before entry clock", 64'(quiet), 64'(WAITC + 1));
        end else begin
          chk(sdata == p_sdata, "R3", "data stable at rise", 64'(sdata), 64'(p_sdata));
          if (bits < 40) cap[bits] = sdata;
          bits++;
        end
      end
      if (fq) stb_w++;
      if (fq && !p_fq) begin
        if (!idone) chk(epulses == 1, "R7", "entry clock pulses", 64'(epulses), 64'd1);
        else begin
          strobes++;
          chk(busy, "R8", "busy during strobe", 64'(busy), 64'd1);
          chk(bits == 40, "R2", "edges per load", 64'(bits), 64'd40);
          if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected load", 64'(cap), 64'd0);
          else begin
            exp_w = exp_q.pop_front();
            chk(cap == exp_w, "R1", "load word", 64'(cap), 64'(exp_w));
          end
        end
      end
      if (!fq && p_fq) begin
        chk(stb_w == STB, "R4", "strobe width", 64'(stb_w), 64'(STB));
        stb_w = 0; bits = 0;
      end
      if (idone && !p_idone)
        chk(epulses == 1 && !fq, "R7", "init done after entry", 64'(epulses), 64'd1);
      p_wclk = wclk; p_fq = fq; p_drst = drst; p_sdata = sdata; p_idone = idone;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(drst && !wclk && !fq, "R5", "pins in reset", {61'd0, drst, wclk, fq}, 64'h4);
    chk(!ready && !idone, "R8", "ready/init in reset", {62'd0, ready, idone}, 64'd0);
    rst_ni = 1'b1;
    do @(negedge clk); while (!idone);
    chk(ready, "R8", "ready after init", 64'(ready), 64'd1);

    send(32'h0000_0000, 1'b0, 5'h00);
    send(32'hFFFF_FFFF, 1'b1, 5'h1F);
    send(32'hA5A5_3C3C, 1'b0, 5'h15);
    send(32'h0000_0001, 1'b0, 5'h00);
    send(32'h8000_0000, 1'b1, 5'h00);
    send(32'h0000_0000, 1'b0, 5'h10);

    // R8: offer a request while busy, withdraw before idle
    send(32'h1234_5678, 1'b0, 5'h0A);
    repeat (10) @(negedge clk);
    ftw = 32'hDEAD_BEEF; valid = 1'b1;
    repeat (30) begin
      @(negedge clk);
      chk(!ready && busy, "R8", "refuse while busy", {62'd0, ready, busy}, 64'd1);
    end
    valid = 1'b0;
    wait_idle();

    // R10: restart mid-load
    send(32'hCAFE_F00D, 1'b1, 5'h07);
    repeat (100) @(negedge clk);
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    exp_q.delete();
    accepted--;
    chk(drst && !idone && !ready, "R10", "restart state",
        {61'd0, drst, idone, ready}, 64'h4);
    do @(negedge clk); while (!idone);
    send(32'h0F0F_F0F0, 1'b0, 5'h03);
    wait_idle();
    repeat (20) @(negedge clk);

    chk(exp_q.size() == 0, "R2", "words left", 64'(exp_q.size()), 64'd0);
    chk(strobes == accepted, "R8", "loads vs accepted", 64'(strobes), 64'(accepted));
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule